// File: doc/BRIEF.md
# Synchronous SRAM Read/Write Datapath

This block holds a small synchronous memory array together with its registered command path and its read output stage. One command is accepted per clock: a read, a write or a deselect. The address arrives already computed by an upstream burst sequencer. Writes are byte-granular. A global write stores every lane. A byte-write enable stores only the lanes whose strobes are low. A write lands in the array at the edge that captures it, so a read of that address in the next cycle returns the new contents.

The read stage can be switched at run time between two timings. In flow-through mode the array output goes straight to the data port, one clock after the read is captured. In pipelined mode the data passes through an output register and appears one clock later. Drive is modelled as an enable flag. It drops as soon as a deselect or write has been captured, with no extra pipeline stage. The active-low output enable and the sleep input gate the drive combinationally. Sleep also blocks all reads and writes while it is high, and the stored contents are kept.

Top module: `ssram_core`

## Requirements
- R1: While reset is asserted, and after it is released until the first read is captured, dq_oe is 0 and rdata is 0.
- R2: With pipe_mode=0, a read captured at clock edge N drives dq_oe=1, with rdata equal to the addressed word, between edge N and edge N+1. A read is desel=0, sleep=0, gw_n=1, bwe_n=1.
- R3: With pipe_mode=1, a read captured at edge N drives its word between edge N+1 and edge N+2. Back-to-back reads each appear for one cycle.
- R4: gw_n=0 (with desel=0, sleep=0) writes all four 8-bit lanes of wdata to addr. This holds whatever bwe_n and bw_n are. Lane k is bits 8k+7..8k.
- R5: gw_n=1, bwe_n=0 writes only the lanes k with bw_n[k]=0. The other lanes keep their previous contents.
- R6: With gw_n=1 and bwe_n=1, bw_n has no effect and no lane is written.
- R7: A deselect (desel=1) or a write captured at edge N removes drive right after edge N in flow-through mode. In pipelined mode it removes drive right after edge N+1, so the preceding read is still presented for its one cycle.
- R8: oe_n=1 forces dq_oe=0 at once, without waiting for a clock edge. It leaves the read pipeline untouched, so drive returns when oe_n falls.
- R9: sleep=1 forces dq_oe=0 at once. Reads and writes presented during sleep are ignored, and the stored words survive.
- R10: A read of an address in the cycle right after a write to it returns the newly written data.
- R11: rdata is 0 whenever dq_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | AW | Word address from the burst sequencer |
| wdata | input | 8*NB | Write data, one byte per lane |
| bw_n | input | NB | Per-lane write strobes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| desel | input | 1 | Deselect command, active high |
| pipe_mode | input | 1 | 1 selects pipelined reads, 0 flow-through |
| oe_n | input | 1 | Output enable, active low, combinational |
| sleep | input | 1 | Low-power mode, active high |
| rdata | output | 8*NB | Read data, zero when not driving |
| dq_oe | output | 1 | Output drive enable |

## Verification
Some properties are checked on every cycle: the zero data bus while not driving, the immediate gating by output enable and by sleep, drive one clock after a read in flow-through mode and two clocks after it in pipelined mode, and drive loss right after a flow-through deselect. The bench's scenarios are needed for everything that depends on stored contents. That covers lane masking, global-write override of the strobes, retention across sleep, read-after-write data, and the pipelined data word itself. The bench compares each cycle against a reference array and latency model. It also shows the asynchronous effect of output enable within a clock cycle.

// File: rtl/ssram_pkg.sv
`timescale 1ns/1ps
package ssram_pkg;
    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } cmd_e;
endpackage

// File: rtl/ssram_ctrl.sv
`timescale 1ns/1ps
module ssram_ctrl
    import ssram_pkg::*;
#(
    parameter int AW = 4,
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [NB-1:0] bw_n,
    input  logic          bwe_n,
    input  logic          gw_n,
    input  logic          desel,
    input  logic          sleep,
    output logic [NB-1:0] we_lane,
    output logic          rd_q,
    output logic [AW-1:0] raddr_q
);
    typedef struct packed {
        logic          rd;
        logic [AW-1:0] addr;
    } st_t;

    st_t  st_d, st_q;
    cmd_e cmd;

    // Command decode and lane write enables
    always_comb begin
        cmd = CMD_IDLE;
        if (!sleep && !desel) begin
            cmd = (!gw_n || !bwe_n) ? CMD_WRITE : CMD_READ;
        end
        for (int b = 0; b < NB; b++) begin
            we_lane[b] = (cmd == CMD_WRITE) && (!gw_n || (!bwe_n && !bw_n[b]));
        end
        st_d.rd   = (cmd == CMD_READ);
        st_d.addr = addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_q    = st_q.rd;
    assign raddr_q = st_q.addr;
endmodule

// File: rtl/ssram_array.sv
`timescale 1ns/1ps
module ssram_array
    import ssram_pkg::*;
#(
    parameter int AW = 4,
    parameter int NB = 4
) (
    input  logic                 clk,
    input  logic [NB-1:0]        we_lane,
    input  logic [AW-1:0]        waddr,
    input  logic [NB*LANE_W-1:0] wdata,
    input  logic [AW-1:0]        raddr,
    output logic [NB*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we_lane[b]) begin
                mem[waddr] <= wdata[b*LANE_W +: LANE_W];
            end
        end

        assign rdata[b*LANE_W +: LANE_W] = mem[raddr];
    end
endmodule

// File: rtl/ssram_outstage.sv
`timescale 1ns/1ps
module ssram_outstage #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] arr_data,
    input  logic         rd_q,
    input  logic         pipe_mode,
    input  logic         oe_n,
    input  logic         sleep,
    output logic [W-1:0] rdata,
    output logic         dq_oe
);
    typedef struct packed {
        logic         v;
        logic [W-1:0] d;
    } st_t;

    st_t          st_d, st_q;
    logic         v_sel;
    logic [W-1:0] d_sel;

    always_comb begin
        st_d.v = rd_q;
        st_d.d = arr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Mode select and combinational drive gating
    always_comb begin
        v_sel = pipe_mode ? st_q.v : rd_q;
        d_sel = pipe_mode ? st_q.d : arr_data;
        dq_oe = v_sel && !oe_n && !sleep;
        rdata = dq_oe ? d_sel : '0;
    end
endmodule

// File: rtl/ssram_core.sv
`timescale 1ns/1ps
module ssram_core
    import ssram_pkg::*;
#(
    parameter int AW = 4,
    parameter int NB = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        addr,
    input  logic [NB*LANE_W-1:0] wdata,
    input  logic [NB-1:0]        bw_n,
    input  logic                 bwe_n,
    input  logic                 gw_n,
    input  logic                 desel,
    input  logic                 pipe_mode,
    input  logic                 oe_n,
    input  logic                 sleep,
    output logic [NB*LANE_W-1:0] rdata,
    output logic                 dq_oe
);
    localparam int W = NB * LANE_W;

    logic [NB-1:0] we_lane;
    logic          rd_q;
    logic [AW-1:0] raddr_q;
    logic [W-1:0]  arr_data;

    ssram_ctrl #(.AW(AW), .NB(NB)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .bw_n    (bw_n),
        .bwe_n   (bwe_n),
        .gw_n    (gw_n),
        .desel   (desel),
        .sleep   (sleep),
        .we_lane (we_lane),
        .rd_q    (rd_q),
        .raddr_q (raddr_q)
    );

    ssram_array #(.AW(AW), .NB(NB)) u_array (
        .clk     (clk),
        .we_lane (we_lane),
        .waddr   (addr),
        .wdata   (wdata),
        .raddr   (raddr_q),
        .rdata   (arr_data)
    );

    ssram_outstage #(.W(W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .arr_data  (arr_data),
        .rd_q      (rd_q),
        .pipe_mode (pipe_mode),
        .oe_n      (oe_n),
        .sleep     (sleep),
        .rdata     (rdata),
        .dq_oe     (dq_oe)
    );
endmodule

// File: rtl/ssram_core_chk.sv
`timescale 1ns/1ps
module ssram_core_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         gw_n,
    input logic         bwe_n,
    input logic         desel,
    input logic         pipe_mode,
    input logic         oe_n,
    input logic         sleep,
    input logic [W-1:0] rdata,
    input logic         dq_oe
);
    logic armed_q, armed2_q;
    logic rd_cmd;

    assign rd_cmd = !desel && !sleep && gw_n && bwe_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q  <= 1'b0;
            armed2_q <= 1'b0;
        end else begin
            armed_q  <= 1'b1;
            armed2_q <= armed_q;
        end
    end

    // R11
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (rdata == '0));

    // R8
    oe_blocks_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);

    // R9
    sleep_blocks_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dq_oe);

    // R2
    flow_read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(rd_cmd) && !pipe_mode && !oe_n && !sleep) |-> dq_oe);

    // R3
    pipe_read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed2_q && $past(rd_cmd, 2) && pipe_mode && !oe_n && !sleep) |-> dq_oe);

    // R7
    flow_desel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(desel) && !pipe_mode) |-> !dq_oe);
endmodule

bind ssram_core ssram_core_chk #(.W(NB * ssram_pkg::LANE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gw_n      (gw_n),
    .bwe_n     (bwe_n),
    .desel     (desel),
    .pipe_mode (pipe_mode),
    .oe_n      (oe_n),
    .sleep     (sleep),
    .rdata     (rdata),
    .dq_oe     (dq_oe)
);

// File: tb/ssram_core_bench.sv
`timescale 1ns/1ps
module ssram_core_bench;
    localparam int AW = 4;
    localparam int NB = 4;
    localparam int W  = 32;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  wdata = '0;
    logic [NB-1:0] bw_n = '1;
    logic          bwe_n = 1'b1;
    logic          gw_n = 1'b1;
    logic          desel = 1'b1;
    logic          pipe_mode = 1'b0;
    logic          oe_n = 1'b0;
    logic          sleep = 1'b0;
    logic [W-1:0]  rdata;
    logic          dq_oe;

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic [W-1:0]  ref_mem [DEPTH];
    logic          m_flv = 1'b0;
    logic [AW-1:0] m_addr = '0;
    logic          m_pv = 1'b0;
    logic [W-1:0]  m_pd = '0;
    logic          last_off = 1'b0;

    always #2.5 clk = ~clk;

    ssram_core #(.AW(AW), .NB(NB)) u_ssram_core (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .bw_n(bw_n),
        .bwe_n(bwe_n), .gw_n(gw_n), .desel(desel), .pipe_mode(pipe_mode),
        .oe_n(oe_n), .sleep(sleep), .rdata(rdata), .dq_oe(dq_oe)
    );

    // Vector layout: {gw_n, bwe_n, bw_n[3:0], desel, sleep, oe_n, pipe, addr[3:0], wdata[31:0]}
    function automatic logic [45:0] mk(input logic gw, input logic bwe, input logic [3:0] bw,
                                       input logic ds, input logic sl, input logic oe,
                                       input logic pp, input logic [3:0] a, input logic [31:0] d);
        return {gw, bwe, bw, ds, sl, oe, pp, a, d};
    endfunction

    function automatic logic [45:0] rdv(input logic [3:0] a, input logic pp);
        return mk(1'b1, 1'b1, 4'hF, 1'b0, 1'b0, 1'b0, pp, a, 32'h0);
    endfunction

    function automatic logic [45:0] dsv(input logic pp);
        return mk(1'b1, 1'b1, 4'hF, 1'b1, 1'b0, 1'b0, pp, 4'h0, 32'h0);
    endfunction

    localparam int NV = 18;
    localparam logic [45:0] VECS [NV] = '{
        rdv(4'd3, 1'b0),                                                    // R2
        rdv(4'd4, 1'b0),                                                    // R2
        dsv(1'b0),                                                          // R7
        rdv(4'd7, 1'b1),                                                    // R3
        rdv(4'd8, 1'b1),                                                    // R3
        rdv(4'd9, 1'b1),                                                    // R3
        dsv(1'b1),                                                          // R7
        dsv(1'b1),                                                          // R7
        mk(1'b0, 1'b0, 4'hF, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2, 32'hDEADBEEF), // R4
        rdv(4'd2, 1'b1),                                                    // R10
        mk(1'b1, 1'b0, 4'hA, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 32'h11223344), // R5
        rdv(4'd2, 1'b0),                                                    // R5
        mk(1'b1, 1'b1, 4'hF, 1'b0, 1'b0, 1'b1, 1'b0, 4'd6, 32'h0),        // R8
        rdv(4'd6, 1'b0),                                                    // R8
        mk(1'b1, 1'b1, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1, 32'hFFFFFFFF), // R6
        rdv(4'd1, 1'b1),                                                    // R6
        mk(1'b1, 1'b1, 4'hF, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2, 32'h0),        // R9
        dsv(1'b0)                                                           // R7
    };

    task automatic check(input string tag, input logic [W-1:0] act_d, input logic act_v,
                         input logic [W-1:0] exp_d, input logic exp_v);
        checks++;
        if (act_v !== exp_v || act_d !== exp_d) begin
            errors++;
            $display("FAIL %s: dq_oe=%0b rdata=%h expected dq_oe=%0b rdata=%h",
                     tag, act_v, act_d, exp_v, exp_d);
        end
    endtask

    task automatic step(input logic [45:0] v, input string tag);
        logic          rdcmd, pv_n, exp_v;
        logic [W-1:0]  pd_n, exp_d;
        string         t;
        @(negedge clk);
        {gw_n, bwe_n, bw_n, desel, sleep, oe_n, pipe_mode, addr, wdata} = v;
        @(posedge clk);
        rdcmd = !desel && !sleep && gw_n && bwe_n;
        pv_n  = m_flv;
        pd_n  = ref_mem[m_addr];
        if (!sleep && !desel) begin
            for (int b = 0; b < NB; b++) begin
                if (!gw_n || (!bwe_n && !bw_n[b])) ref_mem[addr][b*8 +: 8] = wdata[b*8 +: 8];
            end
        end
        m_flv  = rdcmd;
        m_addr = addr;
        m_pv   = pv_n;
        m_pd   = pd_n;
        #1;
        exp_v = (pipe_mode ? m_pv : m_flv) && !oe_n && !sleep;
        exp_d = !exp_v ? '0 : (pipe_mode ? m_pd : ref_mem[m_addr]);
        if (tag != "") t = tag;
        else if (sleep) t = "R9";
        else if (oe_n) t = "R8";
        else if (last_off) t = "R7";
        else if (pipe_mode) t = "R3";
        else t = "R2";
        last_off = desel || !gw_n || !bwe_n;
        check(t, rdata, dq_oe, exp_d, exp_v);
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", rdata, dq_oe, '0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 after release", rdata, dq_oe, '0, 1'b0);

        // Fill the array with known words via global write
        for (int i = 0; i < DEPTH; i++) begin
            step(mk(1'b0, 1'b1, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 4'(i),
                    32'hA5000000 | (32'(i) * 32'h00010203)), "R4 fill");
        end

        for (int n = 0; n < NV; n++) step(VECS[n], "");

        // R10: write then read next cycle, both modes
        step(mk(1'b0, 1'b0, 4'h5, 1'b0, 1'b0, 1'b0, 1'b0, 4'd10, 32'hCAFEF00D), "R4");
        step(rdv(4'd10, 1'b0), "R10 flow");
        step(mk(1'b0, 1'b1, 4'hF, 1'b0, 1'b0, 1'b0, 1'b1, 4'd10, 32'h0BADC0DE), "R7 write");
        step(rdv(4'd10, 1'b1), "R10 pipe issue");
        step(dsv(1'b1), "R10 pipe data");
        step(dsv(1'b1), "R7 pipe off");

        // R5: masked write keeps lanes 0 and 3
        step(mk(1'b1, 1'b0, 4'h9, 1'b0, 1'b0, 1'b0, 1'b0, 4'd11, 32'h77665544), "R5 write");
        step(rdv(4'd11, 1'b0), "R5");

        // R6: strobes low without enables change nothing
        step(mk(1'b1, 1'b1, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd12, 32'h12345678), "R6");
        step(rdv(4'd12, 1'b0), "R6");

        // R9: write during sleep is dropped, contents kept
        step(mk(1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd13, 32'hFEEDFACE), "R9 sleep write");
        step(rdv(4'd13, 1'b0), "R9 retained");

        // R8: output enable acts without a clock edge
        step(rdv(4'd3, 1'b0), "R2");
        #0.5;
        oe_n = 1'b1;
        #0.5;
        check("R8 async off", rdata, dq_oe, '0, 1'b0);
        oe_n = 1'b0;
        #0.5;
        check("R8 async on", rdata, dq_oe, ref_mem[3], 1'b1);
        step(dsv(1'b0), "R7");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule